// File: doc/BRIEF.md
# Programmable Combined Sync Pulse Generator

This block produces one user-defined timing strobe for a video raster. An external raster counter supplies the current pixel index, the line index within the current field and a field flag. The block compares these counts against a programmable horizontal window (start and stop pixel) and a programmable vertical window (start and stop line). It merges the two window hits with a selectable logic operator and passes the result through a polarity stage into a single registered output pin.

The window values and the operator/polarity settings are loaded through a simple write port. New window values are held in a staging copy and take effect only at the start of the next frame, so a pulse is never cut or stretched part way through a frame. Operator and polarity changes apply on the next clock.

Top module: `usg_sync_gen`

## Requirements
- R1: After reset every window value is zero, no operator is selected and the polarity bit is 1, so `sync_out` is 1 (inactive) both during reset and after it until the registers are written.
- R2: The vertical component is active on lines `line_idx` with vstart <= line_idx <= vstop, both ends included (vstart at address 0, vstop at address 1, value in `wr_data[14:0]`).
- R3: The horizontal component is active on pixels with hstart <= pix_idx <= hstop, both ends included, on every line (hstart at address 2, hstop at address 3, value in `wr_data[11:0]`).
- R4: Operator register (address 4) bit 2 set selects AND of the two components; bits 1 and 0 are then ignored.
- R5: Bit 1 set with bit 2 clear selects OR; bit 0 is then ignored.
- R6: Bit 0 alone selects XOR: active when exactly one component is active.
- R7: With bits 2:0 all clear, the combined signal equals the vertical component alone.
- R8: Operator register bit 3 is the polarity: 1 drives the combined signal inverted (active-low output), 0 drives it unchanged (active-high).
- R9: Reserved write bits are discarded: bit 15 of the vertical registers, bits 15:12 of the horizontal registers and bits 15:4 of the operator register have no effect on the output.
- R10: Window writes are staged and become active at the frame boundary, the cycle with field_id = 0, line_idx = 1 and pix_idx = 0; the counts of that cycle are already compared against the new values.
- R11: `sync_out` is registered: it reflects the counts, operator and polarity of the previous clock cycle.
- R12: In the second field (field_id = 1) the same line values apply, counted from that field's own first line, since `line_idx` restarts at 1 each field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_idx | input | 12 | Pixel index within the line, from 0 |
| line_idx | input | 15 | Line index within the field, from 1 |
| field_id | input | 1 | 0 for first field, 1 for second field |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 vstart, 1 vstop, 2 hstart, 3 hstop, 4 operator |
| wr_data | input | 16 | Write data |
| sync_out | output | 1 | Combined, polarity-adjusted timing strobe |

## Verification
The raster is swept across both fields of several frames while the operator register steps through AND, OR with a stray XOR bit, XOR alone, no operator and both polarities; because the horizontal window lies partly inside and partly outside the vertical window, each operator yields a distinct pattern of pixels and lines that separates it from the others. Writes carrying set reserved bits show that only the low field is kept. Window writes issued mid-frame show whether the new values wait for the frame boundary, and the second field shows the line values repeat per field.

// File: rtl/usg_pkg.sv
package usg_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_VSTART = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_VSTOP  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_HSTART = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_HSTOP  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_OPER   = 3'd4;

  // operator select bits, priority high to low
  localparam int SEL_AND = 2;
  localparam int SEL_OR  = 1;
  localparam int SEL_XOR = 0;

  typedef enum logic [1:0] {
    MERGE_VONLY,
    MERGE_XOR,
    MERGE_OR,
    MERGE_AND
  } merge_e;

  function automatic merge_e decode_sel(input logic [2:0] sel);
    if (sel[SEL_AND])      return MERGE_AND;
    else if (sel[SEL_OR])  return MERGE_OR;
    else if (sel[SEL_XOR]) return MERGE_XOR;
    else                   return MERGE_VONLY;
  endfunction

  function automatic logic merge_hits(input merge_e m, input logic h, input logic v);
    case (m)
      MERGE_AND: return h & v;
      MERGE_OR:  return h | v;
      MERGE_XOR: return h ^ v;
      default:   return v;
    endcase
  endfunction

  function automatic logic apply_polarity(input logic pol, input logic c);
    return pol ? ~c : c;
  endfunction
endpackage

// File: rtl/usg_regs.sv
module usg_regs
  import usg_pkg::*;
#(
  parameter int LINE_W = 15,
  parameter int PIX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_bound,
  output logic [LINE_W-1:0] act_vstart,
  output logic [LINE_W-1:0] act_vstop,
  output logic [LINE_W-1:0] eff_vstart,
  output logic [LINE_W-1:0] eff_vstop,
  output logic [PIX_W-1:0]  eff_hstart,
  output logic [PIX_W-1:0]  eff_hstop,
  output logic [2:0]        op_sel,
  output logic              op_pol
);
  localparam int N_WIN = 4;
  localparam int WIN_W = (LINE_W > PIX_W) ? LINE_W : PIX_W;

  logic [WIN_W-1:0] stage_q [N_WIN];
  logic [WIN_W-1:0] live_q  [N_WIN];
  logic [WIN_W-1:0] eff     [N_WIN];
  logic [3:0]       oper_q;

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    // vertical slots keep LINE_W bits, horizontal slots keep PIX_W bits
    localparam int KEEP = (i < 2) ? LINE_W : PIX_W;
    logic [WIN_W-1:0] masked;
    assign masked = WIN_W'(wr_data[KEEP-1:0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q[i] <= '0;
        live_q[i]  <= '0;
      end else begin
        if (frame_bound)
          live_q[i] <= stage_q[i];
        if (wr_en && (wr_addr == ADDR_W'(i)))
          stage_q[i] <= masked;
      end
    end

    assign eff[i] = frame_bound ? stage_q[i] : live_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      oper_q <= 4'b1000;
    else if (wr_en && (wr_addr == ADDR_OPER))
      oper_q <= wr_data[3:0];
  end

  assign act_vstart = live_q[ADDR_VSTART][LINE_W-1:0];
  assign act_vstop  = live_q[ADDR_VSTOP][LINE_W-1:0];
  assign eff_vstart = eff[ADDR_VSTART][LINE_W-1:0];
  assign eff_vstop  = eff[ADDR_VSTOP][LINE_W-1:0];
  assign eff_hstart = eff[ADDR_HSTART][PIX_W-1:0];
  assign eff_hstop  = eff[ADDR_HSTOP][PIX_W-1:0];
  assign op_sel     = oper_q[2:0];
  assign op_pol     = oper_q[3];
endmodule

// File: rtl/usg_window.sv
module usg_window #(
  parameter int W = 15
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);
  function automatic logic inside_closed(input logic [W-1:0] p, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    return (p >= a) && (p <= b);
  endfunction

  assign hit = inside_closed(pos, lo, hi);
endmodule

// File: rtl/usg_combine.sv
module usg_combine
  import usg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       pol,
  input  logic       h_hit,
  input  logic       v_hit,
  output logic       comb,
  output logic       sync_q
);
  merge_e mode;

  assign mode = decode_sel(sel);
  assign comb = merge_hits(mode, h_hit, v_hit);

  always_ff @(posedge clk) begin
    if (!rst_n)
      sync_q <= 1'b1;
    else
      sync_q <= apply_polarity(pol, comb);
  end
endmodule

// File: rtl/usg_sync_gen.sv
module usg_sync_gen
  import usg_pkg::*;
#(
  parameter int LINE_W = 15,
  parameter int PIX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_idx,
  input  logic [LINE_W-1:0] line_idx,
  input  logic              field_id,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sync_out
);
  logic              frame_bound;
  logic [LINE_W-1:0] act_vstart, act_vstop;
  logic [LINE_W-1:0] eff_vstart, eff_vstop;
  logic [PIX_W-1:0]  eff_hstart, eff_hstop;
  logic [2:0]        op_sel;
  logic              op_pol;
  logic              h_hit, v_hit, comb;

  assign frame_bound = !field_id && (line_idx == LINE_W'(1)) && (pix_idx == '0);

  usg_regs #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .frame_bound(frame_bound),
    .act_vstart (act_vstart),
    .act_vstop  (act_vstop),
    .eff_vstart (eff_vstart),
    .eff_vstop  (eff_vstop),
    .eff_hstart (eff_hstart),
    .eff_hstop  (eff_hstop),
    .op_sel     (op_sel),
    .op_pol     (op_pol)
  );

  usg_window #(.W(LINE_W)) u_vwin (
    .pos(line_idx), .lo(eff_vstart), .hi(eff_vstop), .hit(v_hit)
  );

  usg_window #(.W(PIX_W)) u_hwin (
    .pos(pix_idx), .lo(eff_hstart), .hi(eff_hstop), .hit(h_hit)
  );

  usg_combine u_comb (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (op_sel),
    .pol   (op_pol),
    .h_hit (h_hit),
    .v_hit (v_hit),
    .comb  (comb),
    .sync_q(sync_out)
  );
endmodule

// File: rtl/usg_sync_gen_chk.sv
module usg_sync_gen_chk #(
  parameter int LINE_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_bound,
  input logic [LINE_W-1:0] act_vstart,
  input logic [LINE_W-1:0] act_vstop,
  input logic [2:0]        op_sel,
  input logic              op_pol,
  input logic              h_hit,
  input logic              v_hit,
  input logic              comb,
  input logic              sync_out
);
  a_r10_hold_midframe: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_bound |=> ($stable(act_vstart) && $stable(act_vstop)));

  a_r4_and_wins: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[2] |-> (comb == (h_hit && v_hit)));

  a_r5_or_over_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel[2:1] == 2'b01) |-> (comb == (h_hit || v_hit)));

  a_r6_xor_only: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'b001) |-> (comb == (h_hit != v_hit)));

  a_r7_vertical_only: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'b000) |-> (comb == v_hit));

  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (sync_out == ($past(op_pol) ? !$past(comb) : $past(comb))));
endmodule

bind usg_sync_gen usg_sync_gen_chk #(.LINE_W(LINE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_bound(frame_bound),
  .act_vstart (act_vstart),
  .act_vstop  (act_vstop),
  .op_sel     (op_sel),
  .op_pol     (op_pol),
  .h_hit      (h_hit),
  .v_hit      (v_hit),
  .comb       (comb),
  .sync_out   (sync_out)
);

// File: tb/usg_sync_gen_test.sv
module usg_sync_gen_test;
  localparam int CLK_NS = 10;
  localparam int PPL    = 20;
  localparam int LPF    = 12;
  localparam int FRAME  = 2 * PPL * LPF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pix_idx = '0;
  logic [14:0] line_idx = 15'd1;
  logic        field_id = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        sync_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int m_stage[4];
  int m_live[4];
  int m_op;
  int cur_p, cur_l, cur_f;
  string tag;

  usg_sync_gen uut (
    .clk(clk), .rst_n(rst_n), .pix_idx(pix_idx), .line_idx(line_idx),
    .field_id(field_id), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_out(sync_out)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sync_out=%0b expected %0b (line %0d pix %0d field %0d)",
               req, act, exp, cur_l, cur_p, cur_f);
    end
  endtask

  function automatic logic model_out(input int p, input int l, input int f);
    bit fb, h, v, c;
    int vs, ve, hs, he;
    fb = (f == 0) && (l == 1) && (p == 0);
    vs = fb ? m_stage[0] : m_live[0];
    ve = fb ? m_stage[1] : m_live[1];
    hs = fb ? m_stage[2] : m_live[2];
    he = fb ? m_stage[3] : m_live[3];
    v = (l >= vs) && (l <= ve);
    h = (p >= hs) && (p <= he);
    if (m_op & 4)      c = h && v;
    else if (m_op & 2) c = h || v;
    else if (m_op & 1) c = h != v;
    else               c = v;
    return (m_op & 8) ? !c : c;
  endfunction

  task automatic step(input bit we, input int addr, input int data);
    logic exp;
    bit fb;
    @(negedge clk);
    pix_idx  = 12'(cur_p);
    line_idx = 15'(cur_l);
    field_id = cur_f[0];
    wr_en    = we;
    wr_addr  = 3'(addr);
    wr_data  = 16'(data);
    exp = model_out(cur_p, cur_l, cur_f);
    fb = (cur_f == 0) && (cur_l == 1) && (cur_p == 0);
    if (fb) for (int i = 0; i < 4; i++) m_live[i] = m_stage[i];
    if (we) begin
      if (addr < 2)       m_stage[addr] = data % 32768;
      else if (addr < 4)  m_stage[addr] = data % 4096;
      else if (addr == 4) m_op = data % 16;
    end
    @(posedge clk);
    #1;
    if (cur_f == 1) check(sync_out, exp, {tag, " R12 R11"});
    else            check(sync_out, exp, {tag, " R11"});
    cur_p++;
    if (cur_p == PPL) begin
      cur_p = 0;
      cur_l++;
      if (cur_l > LPF) begin
        cur_l = 1;
        cur_f = 1 - cur_f;
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic wr(input int addr, input int data);
    step(1, addr, data);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_stage[i] = 0; m_live[i] = 0; end
    m_op = 8;
    cur_p = 0; cur_l = 1; cur_f = 0;
    tag = "R1";
    // R1: inactive during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(sync_out, 1'b1, "R1 in reset");
    end
    @(negedge clk);
    rst_n = 1'b1;
    run(FRAME);                              // R1 defaults: always inactive
    tag = "R2";
    wr(0, 3); wr(1, 5);                      // vertical lines 3..5 inclusive
    run(2 * FRAME);
    tag = "R9";
    wr(0, 16'h8004);                         // bit 15 set: start becomes 4
    wr(4, 16'hFFF8);                         // op reserved bits: pol 1, no sel
    wr(2, 16'hF002); wr(3, 16'h1006);        // horizontal 2..6, top bits dropped
    run(2 * FRAME);
    tag = "R3 R4";
    wr(2, 4); wr(3, 9); wr(4, 4'b1111);      // AND wins over OR/XOR
    run(2 * FRAME);
    tag = "R5";
    wr(4, 4'b1011);                          // OR, XOR bit ignored
    run(FRAME);
    tag = "R6";
    wr(4, 4'b1001);
    run(FRAME);
    tag = "R7";
    wr(4, 4'b1000);
    run(FRAME);
    tag = "R8";
    wr(4, 4'b0001);                          // XOR active-high
    run(FRAME);
    tag = "R10";
    run(PPL * 4 + 7);                        // move mid-frame
    wr(1, 11); wr(0, 2); wr(2, 0); wr(3, 19);
    run(2 * FRAME);
    tag = "R12";
    wr(0, LPF); wr(1, LPF); wr(4, 4'b1000);  // last line of every field
    run(2 * FRAME);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule